// File: doc/BRIEF.md
# Audio-to-Baseband Sample Rate Measurement Counter

This block estimates how fast a baseband sample stream runs compared with an audio clock, with both seen as one-cycle enable strobes in a single master clock domain. One free-running counter advances on every audio tick, and a second one advances on every received baseband sample. When the audio counter completes a full lap of its range, the block copies the current sample count into a capture register and pulses a valid flag for one cycle.

Neither counter is ever cleared by a capture. Software therefore takes the difference between two successive captured values, modulo the sample counter range, to get the number of baseband samples that arrived in one window of 256 audio ticks. From that it derives the frequency offset between the two clocks.

Top module: `smc_rate_meter`

## Requirements
- R1: The audio counter is 8 bits wide and advances by one on each cycle with `aud_tick_i` high. A capture is triggered when a tick arrives while that counter holds 255, after which the counter wraps to 0. The first capture after reset therefore follows the 256th tick, and later captures follow every further 256 ticks.
- R2: The sample counter is 16 bits wide, advances by one on each cycle with `smp_stb_i` high, and wraps from 65535 to 0.
- R3: On a capture, `smp_count_o` takes the sample count as it stands at the end of the triggering cycle. It is visible from the clock edge that ends that cycle.
- R4: `smp_valid_o` is high for exactly one cycle after each capture, in the cycle in which the new `smp_count_o` first appears, and is low in all other cycles.
- R5: Between captures, `smp_count_o` holds its value regardless of tick or sample strobes.
- R6: A synchronous active-high `rst` sets both counters and `smp_count_o` to zero and `smp_valid_o` low.
- R7: A sample strobe in the same cycle as the triggering audio tick is included in the captured value, so the post-increment count is taken.
- R8: Captures do not clear either counter. Two successive captured values differ, modulo 65536, by the number of sample strobes in the window between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| aud_tick_i | input | 1 | One-cycle audio clock tick strobe |
| smp_stb_i | input | 1 | One-cycle baseband sample-received strobe |
| smp_count_o | output | 16 | Captured sample count |
| smp_valid_o | output | 1 | One-cycle pulse marking a new captured value |

## Verification
Every result appears one clock edge after the cycle whose strobes cause it. A tick that completes a lap makes `smp_valid_o` and the new `smp_count_o` visible together right after that edge, and the captured value already counts a sample strobe from the same cycle. The bench drives strobes on the falling edge, updates its own model of both counters at the rising edge, and compares the outputs one nanosecond after that edge, which is the first cycle in which they are due. Long runs of strobes carry the sample counter through its wrap. Directed laps place a sample strobe on the triggering tick.

// File: rtl/smc_pkg.sv
`timescale 1ns/1ps
package smc_pkg;
  // True when a counter value of width w sits at its top code.
  function automatic logic at_top(input logic [31:0] v, input int unsigned w);
    logic [31:0] top;
    top = (32'd1 << w) - 32'd1;
    return v == top;
  endfunction
endpackage

// File: rtl/smc_event_counter.sv
`timescale 1ns/1ps
module smc_event_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    cnt_nxt = en ? cnt_q + ONE : cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/smc_capture_reg.sv
`timescale 1ns/1ps
module smc_capture_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/smc_rate_meter.sv
`timescale 1ns/1ps
module smc_rate_meter #(
  parameter int AUD_W = 8,
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aud_tick_i,
  input  logic             smp_stb_i,
  output logic [SMP_W-1:0] smp_count_o,
  output logic             smp_valid_o
);
  // Named internal events, brought out for the checker.
  logic [AUD_W-1:0] aud_cnt;
  logic [AUD_W-1:0] aud_nxt;
  logic [SMP_W-1:0] smp_cnt;
  logic [SMP_W-1:0] smp_nxt;
  logic             rollover;

  smc_event_counter #(.W(AUD_W)) u_aud_ctr (
    .clk(clk), .rst(rst), .en(aud_tick_i),
    .cnt_q(aud_cnt), .cnt_nxt(aud_nxt)
  );

  smc_event_counter #(.W(SMP_W)) u_smp_ctr (
    .clk(clk), .rst(rst), .en(smp_stb_i),
    .cnt_q(smp_cnt), .cnt_nxt(smp_nxt)
  );

  // A tick seen at the top code closes one window.
  always_comb begin
    rollover = aud_tick_i && smc_pkg::at_top(32'(aud_cnt), AUD_W);
  end

  // Load the post-increment sample count so a coincident strobe is included.
  smc_capture_reg #(.W(SMP_W)) u_cap (
    .clk(clk), .rst(rst), .load(rollover), .d(smp_nxt),
    .q(smp_count_o), .vld(smp_valid_o)
  );

  logic unused_aud_nxt;
  assign unused_aud_nxt = ^aud_nxt;
endmodule

// File: rtl/smc_rate_meter_chk.sv
`timescale 1ns/1ps
module smc_rate_meter_chk #(
  parameter int AUD_W = 8,
  parameter int SMP_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             aud_tick,
  input logic             smp_stb,
  input logic [AUD_W-1:0] aud_q,
  input logic [SMP_W-1:0] smp_q,
  input logic             rollover,
  input logic [SMP_W-1:0] cap,
  input logic             vld
);
  localparam logic [AUD_W-1:0] AUD_TOP = '1;

  // R1
  aud_step_chk: assert property (@(posedge clk) disable iff (rst)
    aud_tick |=> aud_q == AUD_W'($past(aud_q) + 1'b1));

  // R1
  aud_wrap_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (aud_tick && aud_q == AUD_TOP) |=> vld);

  // R2
  smp_step_chk: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> smp_q == SMP_W'($past(smp_q) + 1'b1));

  // R2
  smp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> $stable(smp_q));

  // R3
  cap_value_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && !$past(rst)) |-> cap == SMP_W'($past(smp_q) + SMP_W'($past(smp_stb))));

  // R4
  vld_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && !$past(rst)) |-> $past(rollover));

  // R4
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    vld |=> !vld || $past(rollover));

  // R5
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!vld && !$past(rst)) |-> $stable(cap));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cap == '0 && !vld && aud_q == '0 && smp_q == '0));
endmodule

bind smc_rate_meter smc_rate_meter_chk #(.AUD_W(AUD_W), .SMP_W(SMP_W)) u_chk (
  .clk(clk), .rst(rst), .aud_tick(aud_tick_i), .smp_stb(smp_stb_i),
  .aud_q(aud_cnt), .smp_q(smp_cnt), .rollover(rollover),
  .cap(smp_count_o), .vld(smp_valid_o)
);

// File: tb/smc_rate_meter_test.sv
`timescale 1ns/1ps
module smc_rate_meter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        aud_tick_i = 1'b0;
  logic        smp_stb_i = 1'b0;
  logic [15:0] smp_count_o;
  logic        smp_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model state
  int m_aud = 0;
  int m_smp = 0;
  int m_cap = 0;
  bit m_vld = 0;
  int prev_cap = 0;
  int win_smp = 0;
  bit have_prev = 0;

  always #2 clk = ~clk;

  smc_rate_meter uut (
    .clk(clk), .rst(rst), .aud_tick_i(aud_tick_i), .smp_stb_i(smp_stb_i),
    .smp_count_o(smp_count_o), .smp_valid_o(smp_valid_o)
  );

  function automatic int wrap8(input int v);  return v & 8'hFF;    endfunction
  function automatic int wrap16(input int v); return v & 16'hFFFF; endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; aud_tick_i = 1'b0; smp_stb_i = 1'b0;
    @(posedge clk); #1;
    m_aud = 0; m_smp = 0; m_cap = 0; m_vld = 0; win_smp = 0; have_prev = 0;
    check("R6 count after reset", smp_count_o, 0);
    check("R6 valid after reset", smp_valid_o, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // One cycle of stimulus; the outputs are compared one edge later.
  task automatic step(input bit tick, input bit stb, input string tag);
    bit wrap;
    @(negedge clk);
    aud_tick_i = tick; smp_stb_i = stb;
    @(posedge clk);
    wrap = tick && (m_aud == 255);
    if (tick) m_aud = wrap8(m_aud + 1);
    if (stb) begin m_smp = wrap16(m_smp + 1); win_smp++; end
    m_vld = wrap;
    if (wrap) m_cap = m_smp;
    #1;
    check({tag, " R4 valid"}, smp_valid_o, m_vld);
    if (wrap) begin
      check({tag, " R3 captured"}, smp_count_o, m_cap);
      if (have_prev)
        check("R8 window delta", wrap16(int'(smp_count_o) - prev_cap), wrap16(win_smp));
      prev_cap = smp_count_o; win_smp = 0; have_prev = 1;
    end else begin
      check({tag, " R5 hold"}, smp_count_o, m_cap);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    // R1: exactly 256 ticks to the first capture, no samples.
    for (int i = 0; i < 256; i++) step(1'b1, 1'b0, "R1 lap");
    // R5: sample strobes without ticks leave the register alone.
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, "R5 idle");

    // R7: coincident sample strobe on the triggering tick.
    for (int i = 0; i < 255; i++) step(1'b1, 1'b0, "R7 lead");
    step(1'b1, 1'b1, "R7 coincident");

    // Random mix of ticks and strobes.
    for (int i = 0; i < 6000; i++)
      step(($urandom % 4) != 0, ($urandom % 3) == 0, "R8 random");

    // R2: carry the sample counter through its wrap.
    for (int i = 0; i < 70000; i++)
      step(($urandom % 64) == 0, 1'b1, "R2 wrap");
    for (int i = 0; i < 600; i++) step(1'b1, 1'b1, "R2 after");

    // R6: reset in mid-lap, then a clean lap.
    for (int i = 0; i < 100; i++) step(1'b1, 1'b1, "R6 pre");
    do_reset();
    for (int i = 0; i < 256; i++) step(1'b1, (i % 2) == 0, "R6 post");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule